// File: doc/BRIEF.md
# Multi-Ring Timer Wheel Tick Engine

This block is the timing core of a hardware timer wheel that serves up to sixteen independent rings. A free-running prescaler, shared by every ring, emits one tick every `PRESCALE` clocks (1024 by default) while the global enable input is high. Each enabled ring holds a 22-bit countdown. When a tick would take that countdown below zero, the ring reloads it from its programmed interval and raises a request to traverse its current bucket. The countdown therefore repeats every interval+1 ticks. A ring that expires again while its earlier traversal is still waiting or in progress is flagged in a per-ring error register. The error register is cleared by writing ones, and a mask turns each error bit into an interrupt.

Traversals are handed one at a time to an external servicing agent through a request, grant and done handshake. The lowest-numbered waiting ring wins. Each ring runs a three-state machine: `RING_IDLE`, `RING_PEND` (expired and waiting) and `RING_ACT` (granted and being walked). The transitions are:
- expiry: `RING_IDLE` to `RING_PEND`
- grant: `RING_PEND` to `RING_ACT`
- done: `RING_ACT` to `RING_IDLE`, or to `RING_PEND` if the ring expires in the same cycle.

The shared arbiter runs `ARB_IDLE`, `ARB_OFFER` and `ARB_BUSY`:
- `ARB_IDLE` to `ARB_OFFER` when the global enable is high and some ring is waiting. The winning ring is latched at this step.
- `ARB_OFFER` to `ARB_BUSY` on grant.
- `ARB_OFFER` back to `ARB_IDLE` if the global enable drops before a grant.
- `ARB_BUSY` to `ARB_IDLE` on done.

Completing a traversal advances the ring's bucket index, wrapping at its bucket count. A one-cycle clear input returns the prescaler, every traversal state and the error bits to zero. The walk of the bucket lists themselves is left to the servicing agent.

Configuration uses two words, each written with the ring number in bits [3:0]. The bucket word carries the bucket count minus one in bits [23:4]. The timing word carries:
- the interval in bits [25:4]
- words per chunk in bits [38:26]
- free-list pool in bits [41:39]
- the ring enable in bit 42.

Top module: `tim_wheel_engine`

## Requirements
- R1: While `glb_enable` is high, `tick` is high for exactly one clock in every `PRESCALE` clocks. While `glb_enable` is low, `tick` stays low and the prescaler holds its count.
- R2: An enabled ring whose countdown is at zero expires on the next tick and reloads its interval. After a timing-word write with interval I, the first expiry comes on the (I+1)-th tick, and every later expiry comes I+1 ticks after the previous one.
- R3: A timing-word write (ring number in bits [3:0], interval in [25:4], enable in bit 42) reloads that ring's countdown with the interval. The write takes precedence over a tick in the same cycle.
- R4: A bucket-word write (bucket count minus one in bits [23:4]) clears the ring's bucket index. Each done advances the index by one and wraps from the programmed count minus one back to 0. `svc_bucket` shows the offered ring's index.
- R5: After a ring's enable is cleared, that ring creates no new traversal. A traversal already waiting for it is still offered and completes.
- R6: While `glb_enable` is low, waiting traversals are not offered (`svc_req` stays low) and remain waiting, and a traversal already granted still accepts done. Once the enable returns, the waiting traversal is offered.
- R7: A ring that expires while in `RING_PEND`, or in `RING_ACT` without done in that cycle, sets its bit in `err_bits` on the following clock.
- R8: An `err_wr` cycle clears exactly the `err_bits` positions that are set in `err_wdata` and leaves all other bits unchanged. A new error in the same cycle wins.
- R9: `irq` is high exactly when some bit is set in both `err_bits` and `int_mask`.
- R10: `svc_req` offers one ring at a time: the lowest-numbered waiting ring at the time of the offer. `svc_grant` makes that ring active, and `svc_done` returns it to idle.
- R11: A one-clock `glb_clear` pulse returns every ring to `RING_IDLE`, withdraws the offer, zeroes `err_bits` and restarts the prescaler, so the next tick comes `PRESCALE` clocks later.
- R12: A timing-word write with a words-per-chunk field below 16 is illegal and is reported by an assertion. A value of 16 is accepted and the ring operates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_enable | input | 1 | Global timer enable |
| glb_clear | input | 1 | One-cycle clear of prescaler, traversal state and errors |
| cfg_wr_a | input | 1 | Write the bucket word |
| cfg_wr_b | input | 1 | Write the timing word |
| cfg_wdata | input | 43 | Configuration word data |
| err_wr | input | 1 | Write-one-to-clear strobe for the error register |
| err_wdata | input | NUM_RINGS | Bits to clear in the error register |
| int_mask | input | NUM_RINGS | Per-ring interrupt enable |
| tick | output | 1 | Prescaler tick |
| svc_req | output | 1 | A traversal is offered |
| svc_ring | output | RW | Ring of the offered or active traversal |
| svc_bucket | output | 20 | Bucket index of that ring |
| svc_grant | input | 1 | Agent accepts the offer |
| svc_done | input | 1 | Agent finished the active traversal |
| err_bits | output | NUM_RINGS | Per-ring overrun flags |
| irq | output | 1 | Masked error interrupt |

## Verification
The hardest situation to reach from the ports is a traversal left waiting while the global enable is low, which the R6 requirement covers. The bench first halts the prescaler and programs two rings so that their expiries follow a known order. It grants the first ring and holds the grant without done. It then disables that ring and lets the second ring expire behind it. Next it drops the global enable, disables the second ring, and only then completes the first traversal. After that, `svc_req` must stay low for many clocks, and it must offer the second ring as soon as the enable returns.

// File: rtl/tim_pkg.sv
package tim_pkg;
    localparam int ID_W      = 4;
    localparam int INTV_W    = 22;
    localparam int BCNT_W    = 20;
    localparam int CHUNK_W   = 13;
    localparam int POOL_W    = 3;
    localparam int ID_LSB    = 0;
    localparam int BCNT_LSB  = ID_LSB + ID_W;
    localparam int INTV_LSB  = ID_LSB + ID_W;
    localparam int CHUNK_LSB = INTV_LSB + INTV_W;
    localparam int POOL_LSB  = CHUNK_LSB + CHUNK_W;
    localparam int ENA_BIT   = POOL_LSB + POOL_W;
    localparam int CFG_W     = ENA_BIT + 1;

    typedef enum logic [1:0] {
        RING_IDLE = 2'd0,
        RING_PEND = 2'd1,
        RING_ACT  = 2'd2
    } ring_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_BUSY  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/tim_prescaler.sv
module tim_prescaler #(
    parameter int PRESCALE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (en)     cnt <= tick ? '0 : cnt + 1'b1;
    end

    generate
        if (PRESCALE > 1) begin : g_gap
            // R1
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tim_ring.sv
module tim_ring
    import tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [BCNT_W-1:0] wr_bcnt_m1,
    input  logic [INTV_W-1:0] wr_intv,
    input  logic              wr_ena,
    input  logic              grant,
    input  logic              done,
    output logic              pending,
    output logic              overrun,
    output logic [BCNT_W-1:0] bucket
);
    ring_state_e       state, state_nxt;
    logic [INTV_W-1:0] cnt, intv;
    logic [BCNT_W-1:0] bcnt_m1;
    logic              ena;
    logic              expire;

    assign expire  = tick && ena && !wr_b && (cnt == '0);
    assign overrun = expire && ((state == RING_PEND) || (state == RING_ACT && !done));
    assign pending = (state == RING_PEND);

    always_comb begin
        state_nxt = state;
        unique case (state)
            RING_IDLE: if (expire) state_nxt = RING_PEND;
            RING_PEND: if (grant)  state_nxt = RING_ACT;
            RING_ACT:  if (done)   state_nxt = expire ? RING_PEND : RING_IDLE;
            default:               state_nxt = RING_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= RING_IDLE;
        else if (clr) state <= RING_IDLE;
        else          state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            intv    <= '0;
            ena     <= 1'b0;
            bcnt_m1 <= '0;
            bucket  <= '0;
        end else begin
            if (wr_b) begin
                cnt  <= wr_intv;
                intv <= wr_intv;
                ena  <= wr_ena;
            end else if (tick && ena) begin
                cnt  <= (cnt == '0) ? intv : cnt - 1'b1;
            end
            if (wr_a) begin
                bcnt_m1 <= wr_bcnt_m1;
                bucket  <= '0;
            end else if (state == RING_ACT && done) begin
                bucket  <= (bucket == bcnt_m1) ? '0 : bucket + 1'b1;
            end
        end
    end

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= intv);
    // R4
    bucket_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bucket <= bcnt_m1);
    // R10
    grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> state == RING_PEND);
    // R10
    done_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == RING_ACT);
endmodule

// File: rtl/tim_arbiter.sv
module tim_arbiter
    import tim_pkg::*;
#(
    parameter int NUM_RINGS = 16,
    parameter int RW        = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 glb_en,
    input  logic [NUM_RINGS-1:0] pend_vec,
    input  logic                 svc_grant,
    input  logic                 svc_done,
    output logic                 svc_req,
    output logic [RW-1:0]        svc_ring,
    output logic [NUM_RINGS-1:0] grant_vec,
    output logic [NUM_RINGS-1:0] done_vec
);
    arb_state_e    state, state_nxt;
    logic [RW-1:0] sel, low;

    always_comb begin
        low = '0;
        for (int i = NUM_RINGS - 1; i >= 0; i--)
            if (pend_vec[i]) low = RW'(i);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ARB_IDLE:  if (glb_en && |pend_vec) state_nxt = ARB_OFFER;
            ARB_OFFER: if (svc_grant)           state_nxt = ARB_BUSY;
                       else if (!glb_en)        state_nxt = ARB_IDLE;
            ARB_BUSY:  if (svc_done)            state_nxt = ARB_IDLE;
            default:                            state_nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
            sel   <= '0;
        end else if (clr) begin
            state <= ARB_IDLE;
        end else begin
            state <= state_nxt;
            if (state == ARB_IDLE) sel <= low;
        end
    end

    always_comb begin
        svc_req   = (state == ARB_OFFER);
        svc_ring  = sel;
        grant_vec = '0;
        done_vec  = '0;
        if (state == ARB_OFFER && svc_grant) grant_vec[sel] = 1'b1;
        if (state == ARB_BUSY && svc_done)   done_vec[sel]  = 1'b1;
    end

    // R10
    offer_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> pend_vec[sel]);
    // R10
    grant_when_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_grant |-> svc_req);
endmodule

// File: rtl/tim_wheel_engine.sv
module tim_wheel_engine
    import tim_pkg::*;
#(
    parameter int NUM_RINGS = 16,
    parameter int PRESCALE  = 1024,
    parameter int MIN_CHUNK = 16,
    localparam int RW = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glb_enable,
    input  logic                 glb_clear,
    input  logic                 cfg_wr_a,
    input  logic                 cfg_wr_b,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 err_wr,
    input  logic [NUM_RINGS-1:0] err_wdata,
    input  logic [NUM_RINGS-1:0] int_mask,
    output logic                 tick,
    output logic                 svc_req,
    output logic [RW-1:0]        svc_ring,
    output logic [BCNT_W-1:0]    svc_bucket,
    input  logic                 svc_grant,
    input  logic                 svc_done,
    output logic [NUM_RINGS-1:0] err_bits,
    output logic                 irq
);
    logic [NUM_RINGS-1:0] pend_vec, ovr_vec, grant_vec, done_vec;
    logic [BCNT_W-1:0]    bkt [NUM_RINGS];
    logic [ID_W-1:0]      wr_id;

    assign wr_id = cfg_wdata[ID_LSB +: ID_W];

    tim_prescaler #(.PRESCALE(PRESCALE)) i_pre (
        .clk(clk), .rst_n(rst_n), .clr(glb_clear), .en(glb_enable), .tick(tick)
    );

    generate
        for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
            tim_ring i_ring (
                .clk        (clk),
                .rst_n      (rst_n),
                .clr        (glb_clear),
                .tick       (tick),
                .wr_a       (cfg_wr_a && wr_id == ID_W'(g)),
                .wr_b       (cfg_wr_b && wr_id == ID_W'(g)),
                .wr_bcnt_m1 (cfg_wdata[BCNT_LSB +: BCNT_W]),
                .wr_intv    (cfg_wdata[INTV_LSB +: INTV_W]),
                .wr_ena     (cfg_wdata[ENA_BIT]),
                .grant      (grant_vec[g]),
                .done       (done_vec[g]),
                .pending    (pend_vec[g]),
                .overrun    (ovr_vec[g]),
                .bucket     (bkt[g])
            );
        end
    endgenerate

    tim_arbiter #(.NUM_RINGS(NUM_RINGS), .RW(RW)) i_arb (
        .clk(clk), .rst_n(rst_n), .clr(glb_clear), .glb_en(glb_enable),
        .pend_vec(pend_vec), .svc_grant(svc_grant), .svc_done(svc_done),
        .svc_req(svc_req), .svc_ring(svc_ring),
        .grant_vec(grant_vec), .done_vec(done_vec)
    );

    assign svc_bucket = bkt[svc_ring];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         err_bits <= '0;
        else if (glb_clear) err_bits <= '0;
        else                err_bits <= (err_bits & ~(err_wr ? err_wdata : '0)) | ovr_vec;
    end

    assign irq = |(err_bits & int_mask);

    // R12
    chunk_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_b |-> cfg_wdata[CHUNK_LSB +: CHUNK_W] >= CHUNK_W'(MIN_CHUNK));
    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wr && !glb_clear && ovr_vec == '0) |=> (err_bits & $past(err_wdata)) == '0);
    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_vec != '0 && !glb_clear) |=> (err_bits & $past(ovr_vec)) == $past(ovr_vec));
endmodule

// File: tb/test_tim_wheel_engine.sv
module test_tim_wheel_engine;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 16;
    localparam int NR = 16;

    localparam int T_RING [4]  = '{0, 9, 12, 15};
    localparam int T_INTV [4]  = '{0, 2, 1, 4};
    localparam int T_BCNT [4]  = '{0, 1, 2, 4};
    localparam int T_TICKS [4] = '{1, 3, 2, 5};

    logic clk = 0, rst_n = 0;
    logic glb_enable = 0, glb_clear = 0, cfg_wr_a = 0, cfg_wr_b = 0;
    logic [42:0] cfg_wdata = '0;
    logic err_wr = 0;
    logic [NR-1:0] err_wdata = '0, int_mask = '0;
    logic svc_grant = 0, svc_done = 0;
    logic tick, svc_req, irq;
    logic [3:0] svc_ring;
    logic [19:0] svc_bucket;
    logic [NR-1:0] err_bits;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tim_wheel_engine #(.NUM_RINGS(NR), .PRESCALE(P)) i_tim_wheel_engine (
        .clk(clk), .rst_n(rst_n), .glb_enable(glb_enable), .glb_clear(glb_clear),
        .cfg_wr_a(cfg_wr_a), .cfg_wr_b(cfg_wr_b), .cfg_wdata(cfg_wdata),
        .err_wr(err_wr), .err_wdata(err_wdata), .int_mask(int_mask),
        .tick(tick), .svc_req(svc_req), .svc_ring(svc_ring), .svc_bucket(svc_bucket),
        .svc_grant(svc_grant), .svc_done(svc_done), .err_bits(err_bits), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [42:0] word_a(input int ring, input int bcnt_m1);
        logic [42:0] w = '0;
        w[3:0]  = 4'(ring);
        w[23:4] = 20'(bcnt_m1);
        return w;
    endfunction

    function automatic logic [42:0] word_b(input int ring, input int intv, input int chunk, input bit ena);
        logic [42:0] w = '0;
        w[3:0]   = 4'(ring);
        w[25:4]  = 22'(intv);
        w[38:26] = 13'(chunk);
        w[41:39] = 3'd2;
        w[42]    = ena;
        return w;
    endfunction

    task automatic write_cfg(input bit is_b, input logic [42:0] w);
        @(negedge clk);
        while (tick) @(negedge clk);
        cfg_wdata = w;
        if (is_b) cfg_wr_b = 1; else cfg_wr_a = 1;
        @(negedge clk);
        cfg_wr_a = 0;
        cfg_wr_b = 0;
    endtask

    task automatic wait_req(output int ticks);
        int guard = 0;
        ticks = 0;
        while (!svc_req && guard < 3000) begin
            if (tick) ticks++;
            @(negedge clk);
            guard++;
        end
        if (!svc_req) begin
            errors++;
            $display("FAIL R10: no request seen, actual 0 expected 1");
        end
    endtask

    task automatic serve(output int ring, output int bkt);
        ring = int'(svc_ring);
        bkt  = int'(svc_bucket);
        svc_grant = 1;
        @(negedge clk);
        svc_grant = 0;
        svc_done = 1;
        @(negedge clk);
        svc_done = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k, r, b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check(svc_req == 0, "R10 reset req", svc_req, 0);
        check(err_bits == 0, "R7 reset err", err_bits, 0);
        check(irq == 0, "R9 reset irq", irq, 0);
        check(tick == 0, "R1 reset tick", tick, 0);

        // R1: tick spacing and halt
        glb_enable = 1;
        while (!tick) @(negedge clk);
        k = 0;
        do begin @(negedge clk); k++; end while (!tick);
        check(k == P, "R1 tick spacing", k, P);
        glb_enable = 0;
        k = 0;
        repeat (40) begin @(negedge clk); if (tick) k++; end
        check(k == 0, "R1 halted ticks", k, 0);
        glb_enable = 1;

        // Table: R2 R3 R4 R10 R12 (chunk 16 accepted)
        for (int e = 0; e < 4; e++) begin
            write_cfg(0, word_a(T_RING[e], T_BCNT[e]));
            write_cfg(1, word_b(T_RING[e], T_INTV[e], 16, 1));
            for (int s = 0; s < 3; s++) begin
                wait_req(k);
                check(k == T_TICKS[e], "R2 R3 ticks to expiry", k, T_TICKS[e]);
                serve(r, b);
                check(r == T_RING[e], "R10 offered ring", r, T_RING[e]);
                check(b == s % (T_BCNT[e] + 1), "R4 bucket index", b, s % (T_BCNT[e] + 1));
            end
            write_cfg(1, word_b(T_RING[e], T_INTV[e], 16, 0));
        end
        check(err_bits == 0, "R12 R7 no error in table", err_bits, 0);

        // R4: bucket word write clears index
        write_cfg(0, word_a(12, 2));
        write_cfg(1, word_b(12, 0, 16, 1));
        wait_req(k);
        serve(r, b);
        write_cfg(1, word_b(12, 0, 16, 0));
        check(b == 0, "R4 cleared by bucket word", b, 0);

        // R7 R9 R5 R8
        int_mask = '0;
        write_cfg(1, word_b(2, 0, 20, 1));
        wait_req(k);
        while (!tick) @(negedge clk);
        repeat (2) @(negedge clk);
        check(err_bits == 16'h0004, "R7 overrun sets bit", err_bits, 4);
        check(irq == 0, "R9 masked irq", irq, 0);
        int_mask = 16'h0004;
        #1;
        check(irq == 1, "R9 enabled irq", irq, 1);
        int_mask = 16'hFFFB;
        #1;
        check(irq == 0, "R9 other bits irq", irq, 0);
        write_cfg(1, word_b(2, 0, 20, 0));
        repeat (40) @(negedge clk);
        check(svc_req == 1 && svc_ring == 2, "R5 pending survives disable", svc_ring, 2);
        serve(r, b);
        k = 0;
        repeat (60) begin @(negedge clk); if (svc_req) k++; end
        check(k == 0, "R5 no new traversal", k, 0);
        err_wr = 1; err_wdata = 16'h0001;
        @(negedge clk);
        err_wr = 0;
        check(err_bits == 16'h0004, "R8 unselected bit kept", err_bits, 4);
        err_wr = 1; err_wdata = 16'h0004;
        @(negedge clk);
        err_wr = 0;
        check(err_bits == 0, "R8 selected bit cleared", err_bits, 0);

        // R6: waiting traversal held across global disable
        glb_enable = 0;
        write_cfg(1, word_b(6, 0, 16, 1));
        write_cfg(1, word_b(7, 1, 16, 1));
        glb_enable = 1;
        wait_req(k);
        check(svc_ring == 6, "R6 first ring", svc_ring, 6);
        svc_grant = 1;
        @(negedge clk);
        svc_grant = 0;
        write_cfg(1, word_b(6, 0, 16, 0));
        repeat (24) @(negedge clk);
        check(svc_req == 0, "R10 no offer while busy", svc_req, 0);
        glb_enable = 0;
        write_cfg(1, word_b(7, 1, 16, 0));
        svc_done = 1;
        @(negedge clk);
        svc_done = 0;
        k = 0;
        repeat (30) begin @(negedge clk); if (svc_req) k++; end
        check(k == 0, "R6 no offer while disabled", k, 0);
        glb_enable = 1;
        repeat (2) @(negedge clk);
        check(svc_req == 1, "R6 offer after enable", svc_req, 1);
        check(svc_ring == 7, "R6 held ring offered", svc_ring, 7);
        serve(r, b);
        check(err_bits == 0, "R6 no error", err_bits, 0);

        // R11: soft clear
        write_cfg(1, word_b(4, 0, 16, 1));
        wait_req(k);
        while (!tick) @(negedge clk);
        repeat (2) @(negedge clk);
        write_cfg(1, word_b(4, 0, 16, 0));
        check(err_bits == 16'h0010, "R11 error before clear", err_bits, 16);
        @(negedge clk);
        glb_clear = 1;
        @(negedge clk);
        glb_clear = 0;
        check(svc_req == 0, "R11 offer withdrawn", svc_req, 0);
        check(err_bits == 0, "R11 errors cleared", err_bits, 0);
        k = 1;
        while (!tick && k < 100) begin @(negedge clk); k++; end
        check(k == P, "R11 prescaler restarted", k, P);
        k = 0;
        repeat (40) begin @(negedge clk); if (svc_req) k++; end
        check(k == 0, "R11 no pending left", k, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule